// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to a few hundred peripheral interrupt lines and forwards one of them to a processor core. A rising edge on a line marks it pending. Each line also has an enable bit and an 8-bit priority byte, all held in 32-bit registers. In every cycle the controller looks at the lines that are both enabled and pending and picks a winner. The lowest arbitration level wins, and when levels are equal the lowest line number wins. The winner is offered to the core as a request strobe together with its line number.

Two gates sit between the winner and the core. The first is a base-priority threshold. The second is a preemption test against the level of the handler that is running now. The controller keeps a stack of the levels of handlers that have been taken and not yet finished. An acknowledge from the core pushes the winner's level onto this stack and clears that line's pending bit. A done pulse pops the stack.

Software reaches the enable and pending state through separate set and clear words. A 1 written to a bit acts on that line, and a 0 leaves it alone. Priorities are written four bytes to a word.

Top module: `pic_top`

## Requirements
- R1: A 1 written to bit b of enable-set word w (address 0x00+w) enables line 32*w+b. A 1 written to enable-clear word w (address 0x08+w) disables that line. Bits written as 0 change nothing. Both addresses read back the current enable word.
- R2: Pending-set words (0x10+w) and pending-clear words (0x18+w) use the same write-one rule and read back the pending word. Clearing a pending line drops its unserved request.
- R3: Line n has its enable and pending bits in word n/32 at bit n mod 32. Its priority byte sits at bits 8*(n mod 4)+7 down to 8*(n mod 4) of priority word n/4, at address 0x40+n/4.
- R4: The arbitration level is bits 7:5 of the priority byte. Bits 4:0 are stored and read back but do not affect which line wins.
- R5: The candidate with the smallest level wins, and among equal levels the lowest line number wins. The request line is high only while a candidate survives the gates, and core_id names the winner.
- R6: The mask register (0x20) keeps only bits 7:5 and reads the other bits as 0. A stored value of 0 disables masking. A nonzero value M blocks every winner whose level is M or greater.
- R7: A line that is pending while disabled is not requested, but it stays pending. It is requested once it is enabled.
- R8: A rising edge on irq_in sets the line's pending bit. A line held high does not pend again after its request is acknowledged.
- R9: An acknowledge while core_req is high clears the winner's pending bit and makes its level active. An acknowledge while core_req is low is ignored.
- R10: The grouping register (0x21, bits 2:0) gives the number of leading level bits that count for preemption. Values 3 to 7 behave as 3, and a value of 0 allows no preemption. While a handler is active, a winner is requested only if its preemption part is strictly smaller than that of the active level.
- R11: core_done ends the innermost active handler and restores the level that was active before it. A done pulse with nothing active is ignored.
- R12: After reset all enables, pending bits, priorities, the mask and the grouping are zero, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NLINES | Interrupt lines; a rising edge marks a line pending |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 7 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 7 | Read word address |
| reg_rdata | output | 32 | Read data (combinational) |
| core_req | output | 1 | Request to the core |
| core_id | output | $clog2(NLINES) | Line number of the winning request |
| core_ack | input | 1 | Core takes the offered request |
| core_done | input | 1 | Core finishes the innermost handler |

## Verification
The hardest states to reach are nested handlers: several levels on the active stack, with the grouping changed while they are active, so that the preemption test works on coarser fields than the ones used when the handlers were taken. Directed sequences first acknowledge a low-urgency line and then raise more urgent ones under different grouping values. A long random phase then toggles lines, rewrites priorities, mask and grouping, and acknowledges and finishes handlers at random. Throughout, a bench model keeps its own stack and predicts the request and the winning line in every cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int LVL_W   = 3;
   localparam int PRIO_W  = 8;
   localparam int ADDR_W  = 7;

   localparam logic [ADDR_W-1:0] A_ENSET = 7'h00;
   localparam logic [ADDR_W-1:0] A_ENCLR = 7'h08;
   localparam logic [ADDR_W-1:0] A_PSET  = 7'h10;
   localparam logic [ADDR_W-1:0] A_PCLR  = 7'h18;
   localparam logic [ADDR_W-1:0] A_MASK  = 7'h20;
   localparam logic [ADDR_W-1:0] A_GROUP = 7'h21;
   localparam logic [ADDR_W-1:0] A_PRIO  = 7'h40;

   typedef logic [LVL_W-1:0] lvl_t;

   // part of a level that counts for preemption under grouping g
   function automatic lvl_t preempt_part(lvl_t l, logic [2:0] g);
      int pb;
      pb = (int'(g) >= LVL_W) ? LVL_W : int'(g);
      return lvl_t'(l >> (LVL_W - pb));
   endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
   import pic_pkg::*;
#(
   parameter int NLINES = 64,
   localparam int IDW   = $clog2(NLINES),
   localparam int NWORD = NLINES / 32,
   localparam int NPRW  = NLINES / 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NLINES-1:0]             irq_in,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [31:0]                   wr_data,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [31:0]                   rd_data,
   input  logic                          ack_ok,
   input  logic [IDW-1:0]                ack_id,
   output logic [NLINES-1:0]             en_o,
   output logic [NLINES-1:0]             pend_o,
   output logic [NLINES-1:0][LVL_W-1:0]  lvl_o,
   output lvl_t                          mask_o,
   output logic [2:0]                    grp_o
);
   logic [NLINES-1:0]             en_q, pend_q, irq_q;
   logic [NLINES-1:0][PRIO_W-1:0] prio_q;
   lvl_t                          mask_q;
   logic [2:0]                    grp_q;

   logic [NLINES-1:0] en_set_v, en_clr_v, p_set_v, p_clr_v, edge_v, ack_v;

   assign edge_v = irq_in & ~irq_q;
   assign ack_v  = ack_ok ? (NLINES'(1) << ack_id) : '0;

   for (genvar w = 0; w < NWORD; w++) begin : g_word
      assign en_set_v[32*w +: 32] = (wr_en && wr_addr == A_ENSET + ADDR_W'(w)) ? wr_data : '0;
      assign en_clr_v[32*w +: 32] = (wr_en && wr_addr == A_ENCLR + ADDR_W'(w)) ? wr_data : '0;
      assign p_set_v[32*w +: 32]  = (wr_en && wr_addr == A_PSET  + ADDR_W'(w)) ? wr_data : '0;
      assign p_clr_v[32*w +: 32]  = (wr_en && wr_addr == A_PCLR  + ADDR_W'(w)) ? wr_data : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
         irq_q  <= '0;
         mask_q <= '0;
         grp_q  <= '0;
      end else begin
         irq_q  <= irq_in;
         en_q   <= (en_q | en_set_v) & ~en_clr_v;
         pend_q <= (pend_q & ~(p_clr_v | ack_v)) | p_set_v | edge_v;
         if (wr_en && wr_addr == A_MASK)  mask_q <= wr_data[PRIO_W-1 -: LVL_W];
         if (wr_en && wr_addr == A_GROUP) grp_q  <= wr_data[2:0];
      end
   end

   for (genvar i = 0; i < NLINES; i++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_q[i] <= '0;
         else if (wr_en && wr_addr == A_PRIO + ADDR_W'(i / 4))
            prio_q[i] <= wr_data[8*(i%4) +: 8];
      end
      assign lvl_o[i] = prio_q[i][PRIO_W-1 -: LVL_W];
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < NWORD; w++) begin
         if (rd_addr == A_ENSET + ADDR_W'(w) || rd_addr == A_ENCLR + ADDR_W'(w))
            rd_data = en_q[32*w +: 32];
         if (rd_addr == A_PSET + ADDR_W'(w) || rd_addr == A_PCLR + ADDR_W'(w))
            rd_data = pend_q[32*w +: 32];
      end
      for (int p = 0; p < NPRW; p++) begin
         if (rd_addr == A_PRIO + ADDR_W'(p))
            rd_data = {prio_q[4*p+3], prio_q[4*p+2], prio_q[4*p+1], prio_q[4*p]};
      end
      if (rd_addr == A_MASK)  rd_data = {24'd0, mask_q, 5'd0};
      if (rd_addr == A_GROUP) rd_data = {29'd0, grp_q};
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;
   assign mask_o = mask_q;
   assign grp_o  = grp_q;

   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_q)); // R1

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ok && edge_v == '0 && p_set_v == '0) |=> !pend_q[$past(ack_id)]); // R9
endmodule

// File: rtl/pic_select.sv
module pic_select
   import pic_pkg::*;
#(
   parameter int NLINES = 64,
   localparam int IDW   = $clog2(NLINES)
) (
   input  logic [NLINES-1:0]            cand,
   input  logic [NLINES-1:0][LVL_W-1:0] lvl,
   output logic                         any,
   output logic [IDW-1:0]               win_id,
   output lvl_t                         win_lvl
);
   // downward scan: with <= the lowest index wins on equal levels
   always_comb begin
      any     = 1'b0;
      win_id  = '0;
      win_lvl = '1;
      for (int i = NLINES - 1; i >= 0; i--) begin
         if (cand[i] && (!any || lvl[i] <= win_lvl)) begin
            any     = 1'b1;
            win_id  = IDW'(i);
            win_lvl = lvl[i];
         end
      end
   end
endmodule

// File: rtl/pic_nest.sv
module pic_nest
   import pic_pkg::*;
#(
   localparam int NEST = 1 << LVL_W,
   localparam int SW   = $clog2(NEST),
   localparam int DW   = $clog2(NEST + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] grp,
   input  lvl_t       mask,
   input  logic       any,
   input  lvl_t       win_lvl,
   input  logic       ack,
   input  logic       done,
   output logic       req,
   output logic       ack_ok
);
   lvl_t [NEST-1:0] stk_q;
   logic [DW-1:0]   depth_q;
   lvl_t            act_lvl;
   logic            blocked, pre_ok, pop;
   logic [DW-1:0]   d_after_pop;

   assign act_lvl = stk_q[SW'(depth_q - 1'b1)];
   assign blocked = (mask != '0) && (win_lvl >= mask);
   assign pre_ok  = (depth_q == '0) ||
                    (preempt_part(win_lvl, grp) < preempt_part(act_lvl, grp));
   assign req     = any && !blocked && pre_ok;
   assign ack_ok  = ack && req;
   assign pop     = done && (depth_q != '0);
   assign d_after_pop = depth_q - DW'(pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stk_q   <= '0;
         depth_q <= '0;
      end else begin
         if (ack_ok) stk_q[SW'(d_after_pop)] <= win_lvl;
         depth_q <= d_after_pop + DW'(ack_ok);
      end
   end

   AST_NEST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ok && depth_q != '0) |-> (win_lvl < act_lvl)); // R10

   AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !ack_ok) |=> (depth_q == $past(depth_q) - 1'b1)); // R11

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ack_ok |-> (d_after_pop < DW'(NEST))); // R10
endmodule

// File: rtl/pic_top.sv
module pic_top
   import pic_pkg::*;
#(
   parameter int NLINES = 64,
   localparam int IDW   = $clog2(NLINES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NLINES-1:0]   irq_in,
   input  logic                reg_wr,
   input  logic [6:0]          reg_waddr,
   input  logic [31:0]         reg_wdata,
   input  logic [6:0]          reg_raddr,
   output logic [31:0]         reg_rdata,
   output logic                core_req,
   output logic [IDW-1:0]      core_id,
   input  logic                core_ack,
   input  logic                core_done
);
   if (NLINES % 32 != 0 || NLINES < 32 || NLINES > 256) begin : g_bad_lines
      $error("pic_top: NLINES must be a multiple of 32 between 32 and 256");
   end

   logic [NLINES-1:0]            en, pend;
   logic [NLINES-1:0][LVL_W-1:0] lvl;
   lvl_t                         mask, win_lvl;
   logic [2:0]                   grp;
   logic                         any, ack_ok;
   logic [IDW-1:0]               win_id;

   pic_regs #(.NLINES(NLINES)) u_regs (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
      .rd_addr(reg_raddr), .rd_data(reg_rdata),
      .ack_ok(ack_ok), .ack_id(win_id),
      .en_o(en), .pend_o(pend), .lvl_o(lvl), .mask_o(mask), .grp_o(grp)
   );

   pic_select #(.NLINES(NLINES)) u_sel (
      .cand(en & pend), .lvl(lvl),
      .any(any), .win_id(win_id), .win_lvl(win_lvl)
   );

   pic_nest u_nest (
      .clk(clk), .rst_n(rst_n), .grp(grp), .mask(mask),
      .any(any), .win_lvl(win_lvl), .ack(core_ack), .done(core_done),
      .req(core_req), .ack_ok(ack_ok)
   );

   assign core_id = win_id;

   AST_REQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> (en[core_id] && pend[core_id])); // R7

   AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && mask != '0) |-> (lvl[core_id] < mask)); // R6

   AST_NO_LOWER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> !(en[0] && pend[0] && lvl[0] < lvl[core_id])); // R5
endmodule

// File: tb/sim_pic_top.sv
`timescale 1ns/1ps
module sim_pic_top;
   localparam int N = 64;
   localparam int IDW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic reg_wr = 1'b0;
   logic [6:0] reg_waddr = '0, reg_raddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic core_req, core_ack = 1'b0, core_done = 1'b0;
   logic [IDW-1:0] core_id;

   always #10 clk = ~clk;

   pic_top #(.NLINES(N)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .core_req(core_req), .core_id(core_id),
      .core_ack(core_ack), .core_done(core_done)
   );

   int total = 0, bad = 0;
   bit finished = 0;
   string cur_tag = "R12";

   // bench model
   logic [N-1:0] m_en = '0, m_pend = '0, m_prev = '0;
   logic [7:0]   m_prio [N];
   logic [2:0]   m_mask = '0, m_grp = '0;
   logic [2:0]   m_stk [8];
   int           m_depth = 0;
   logic         e_req;
   int           e_id;
   logic [2:0]   e_lvl;

   function automatic logic [2:0] pp(logic [2:0] l);
      int pb = (m_grp > 3) ? 3 : int'(m_grp);
      return 3'(l >> (3 - pb));
   endfunction

   function automatic void exp_calc();
      bit any = 0;
      logic [2:0] best = 0;
      int id = 0;
      for (int i = N - 1; i >= 0; i--) begin
         if (m_en[i] && m_pend[i] && (!any || m_prio[i][7:5] <= best)) begin
            any = 1; best = m_prio[i][7:5]; id = i;
         end
      end
      e_lvl = best;
      e_id  = id;
      e_req = any && !(m_mask != 0 && best >= m_mask) &&
              (m_depth == 0 || pp(best) < pp(m_stk[m_depth-1]));
   endfunction

   function automatic logic [31:0] mread(logic [6:0] a);
      if (a == 7'h00 || a == 7'h08) return m_en[31:0];
      if (a == 7'h01 || a == 7'h09) return m_en[63:32];
      if (a == 7'h10 || a == 7'h18) return m_pend[31:0];
      if (a == 7'h11 || a == 7'h19) return m_pend[63:32];
      if (a == 7'h20) return {24'd0, m_mask, 5'd0};
      if (a == 7'h21) return {29'd0, m_grp};
      if (a >= 7'h40 && a < 7'h50) begin
         int p = int'(a) - 'h40;
         return {m_prio[4*p+3], m_prio[4*p+2], m_prio[4*p+1], m_prio[4*p]};
      end
      return 32'd0;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input logic [6:0] a, input string tag);
      reg_raddr = a;
      #1;
      chk(reg_rdata, mread(a), tag);
   endtask

   // one clock: drive at negedge, model the edge, compare at next negedge
   task automatic cyc(input logic [N-1:0] irq, input logic we, input logic [6:0] wa,
                      input logic [31:0] wd, input logic ak, input logic dn);
      logic [N-1:0] edges, pset, pclr, eset, eclr, ackv;
      logic take;
      irq_in = irq; reg_wr = we; reg_waddr = wa; reg_wdata = wd;
      core_ack = ak; core_done = dn;
      exp_calc();
      take = ak && e_req;
      @(posedge clk);
      edges = irq & ~m_prev; m_prev = irq;
      pset = '0; pclr = '0; eset = '0; eclr = '0;
      if (we) begin
         if (wa == 7'h00) eset[31:0] = wd;
         if (wa == 7'h01) eset[63:32] = wd;
         if (wa == 7'h08) eclr[31:0] = wd;
         if (wa == 7'h09) eclr[63:32] = wd;
         if (wa == 7'h10) pset[31:0] = wd;
         if (wa == 7'h11) pset[63:32] = wd;
         if (wa == 7'h18) pclr[31:0] = wd;
         if (wa == 7'h19) pclr[63:32] = wd;
         if (wa == 7'h20) m_mask = wd[7:5];
         if (wa == 7'h21) m_grp = wd[2:0];
         if (wa >= 7'h40 && wa < 7'h50)
            for (int k = 0; k < 4; k++) m_prio[4*(int'(wa) - 'h40) + k] = wd[8*k +: 8];
      end
      ackv = take ? (N'(1) << e_id) : '0;
      m_pend = (m_pend & ~(pclr | ackv)) | pset | edges;
      m_en = (m_en | eset) & ~eclr;
      if (dn && m_depth > 0) m_depth--;
      if (take) begin m_stk[m_depth] = e_lvl; m_depth++; end
      @(negedge clk);
      reg_wr = 0; core_ack = 0; core_done = 0;
      exp_calc();
      chk({31'd0, core_req}, {31'd0, e_req}, cur_tag);
      if (e_req) chk({26'd0, core_id}, e_id, cur_tag);
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      cyc(irq_in, 1'b1, a, d, 1'b0, 1'b0);
   endtask
   task automatic idle();
      cyc(irq_in, 1'b0, 7'h7F, 32'd0, 1'b0, 1'b0);
   endtask
   task automatic ack();
      cyc(irq_in, 1'b0, 7'h7F, 32'd0, 1'b1, 1'b0);
   endtask
   task automatic fin();
      cyc(irq_in, 1'b0, 7'h7F, 32'd0, 1'b0, 1'b1);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < N; i++) m_prio[i] = '0;
      for (int i = 0; i < 8; i++) m_stk[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      chk({31'd0, core_req}, 32'd0, "R12");
      rd_chk(7'h00, "R12"); rd_chk(7'h11, "R12"); rd_chk(7'h45, "R12");
      rd_chk(7'h20, "R12"); rd_chk(7'h21, "R12");

      // R1: write-one enable semantics
      cur_tag = "R1";
      wr(7'h00, 32'h5);
      rd_chk(7'h00, "R1"); rd_chk(7'h08, "R1");
      chk(reg_rdata, 32'h5, "R1");
      wr(7'h00, 32'h0); wr(7'h08, 32'h4); wr(7'h08, 32'h0);
      rd_chk(7'h00, "R1");
      chk(reg_rdata, 32'h1, "R1");
      wr(7'h08, 32'h1);

      // R2: pend set / clear, clearing drops request
      cur_tag = "R2";
      wr(7'h10, 32'h4);
      rd_chk(7'h18, "R2");
      chk(reg_rdata, 32'h4, "R2");
      wr(7'h18, 32'h4);
      rd_chk(7'h10, "R2");
      chk(reg_rdata, 32'h0, "R2");

      // R7: pended while disabled, requested when enabled
      cur_tag = "R7";
      wr(7'h10, 32'h4); idle();
      chk({31'd0, core_req}, 32'd0, "R7");
      wr(7'h00, 32'h4);
      chk({31'd0, core_req}, 32'd1, "R7");
      chk({26'd0, core_id}, 32'd2, "R7");

      // R9: acknowledge clears pending, ack without request ignored
      cur_tag = "R9";
      ack();
      rd_chk(7'h10, "R9");
      chk(reg_rdata, 32'h0, "R9");
      ack(); fin();

      // R3: line 37 positions
      cur_tag = "R3";
      wr(7'h49, 32'h0000_A500);
      rd_chk(7'h49, "R3");
      wr(7'h01, 32'h20); wr(7'h11, 32'h20);
      chk({26'd0, core_id}, 32'd37, "R3");
      ack(); fin();

      // R5 / R4: lowest level, then lowest index, low bits ignored
      cur_tag = "R5";
      wr(7'h00, 32'hA);
      wr(7'h40, 32'h4000_6000);
      wr(7'h10, 32'hA);
      chk({26'd0, core_id}, 32'd3, "R5");
      cur_tag = "R4";
      wr(7'h40, 32'h4100_5F00);
      rd_chk(7'h40, "R4");
      chk({26'd0, core_id}, 32'd1, "R4");

      // R6: mask threshold and its stored bits
      cur_tag = "R6";
      wr(7'h20, 32'h5F);
      rd_chk(7'h20, "R6");
      chk(reg_rdata, 32'h40, "R6");
      chk({31'd0, core_req}, 32'd0, "R6");
      wr(7'h20, 32'h1F);
      chk({31'd0, core_req}, 32'd1, "R6");
      wr(7'h18, 32'hA);

      // R8: edge pends, held level does not re-pend
      cur_tag = "R8";
      wr(7'h00, 32'h10);
      cyc(N'(64'h10), 1'b0, 7'h7F, 0, 1'b0, 1'b0);
      chk({26'd0, core_id}, 32'd4, "R8");
      ack(); idle(); idle();
      rd_chk(7'h10, "R8");
      chk(reg_rdata[4], 1'b0, "R8");
      fin();
      cyc('0, 1'b0, 7'h7F, 0, 1'b0, 1'b0);

      // R10: preemption under grouping values; R11 pop
      cur_tag = "R10";
      wr(7'h41, 32'h0000_0080); // line 4 level 4
      wr(7'h40, 32'h0000_A040); // line 0 level 2, line 1 level 5
      wr(7'h00, 32'h3);
      wr(7'h21, 32'h3);
      wr(7'h10, 32'h10);
      ack();                    // line 4 active at level 4
      wr(7'h10, 32'h2); idle();
      chk({31'd0, core_req}, 32'd0, "R10");
      wr(7'h21, 32'h1);         // 5 vs 4 share top bit
      chk({31'd0, core_req}, 32'd0, "R10");
      wr(7'h10, 32'h1);
      chk({31'd0, core_req}, 32'd1, "R10");
      wr(7'h21, 32'h0);
      chk({31'd0, core_req}, 32'd0, "R10");
      wr(7'h21, 32'h7);
      chk({31'd0, core_req}, 32'd1, "R10");
      ack();                    // line 0 nested at level 2
      cur_tag = "R11";
      fin();
      chk({31'd0, core_req}, 32'd0, "R11");
      fin();
      chk({31'd0, core_req}, 32'd1, "R11");
      chk({26'd0, core_id}, 32'd1, "R11");
      fin(); fin();

      // random phase
      cur_tag = "R5";
      for (int c = 0; c < 4000; c++) begin
         logic [N-1:0] irq = irq_in;
         logic we = ($urandom % 4) == 0;
         logic [6:0] wa;
         logic [31:0] wd = $urandom;
         int r = $urandom % 8;
         if (($urandom % 4) == 0) irq[$urandom % N] = ~irq[$urandom % N];
         case (r)
            0: wa = 7'(($urandom % 2));
            1: wa = 7'h08 + 7'(($urandom % 2));
            2: wa = 7'h10 + 7'(($urandom % 2));
            3: begin wa = 7'h18 + 7'(($urandom % 2)); wd = wd & $urandom; end
            4: wa = 7'h20;
            5: wa = 7'h21;
            default: wa = 7'h40 + 7'(($urandom % 16));
         endcase
         if (r == 1) wd = wd & $urandom & $urandom;
         cyc(irq, we, wa, wd, ($urandom % 2) == 0, ($urandom % 6) == 0);
         if ((c % 97) == 0) rd_chk(7'(($urandom % 2) ? 7'h10 : 7'h40 + ($urandom % 16)), "R2");
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule